// File: doc/BRIEF.md
# CPU Power Mode Controller

This block governs the two suspension depths of a small 8-bit microcontroller core. Software writes a one-byte power control register. Bit 0 requests a light suspension in which only instruction execution pauses. Bit 1 requests a deep suspension in which the core, the timers and the main clock all stop. The block drives three enables to the rest of the chip: one that lets the core fetch and execute, one for the peripheral and timer clock domain, and one for the main clock.

The two depths end in different ways. A light suspension ends on any interrupt, whether it is a pending interrupt already resolved by the interrupt controller or a raw external request. A deep suspension ends only on an external request or on reset. The external request reaches the clock enables through combinational logic, so it restarts the clocks even though the timer domain is stopped. The register bit is cleared on the same edge that returns the run enable to 1. While either suspension is active the core cannot execute, so writes to the register are not accepted.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset both mode bits are clear: cpu_run_en, periph_clk_en and main_clk_en are all 1.
- R2: While running, a write with bit 0 = 1 and bit 1 = 0 enters the light suspension on the next edge: cpu_run_en = 0, periph_clk_en = 1, main_clk_en = 1.
- R3: In the light suspension, irq_pending = 1 or ext_irq = 1 at a clock edge ends it, and cpu_run_en is 1 after that edge.
- R4: While running, a write with bit 1 = 1 enters the deep suspension on the next edge: cpu_run_en = 0, and with ext_irq = 0 both clock enables are 0.
- R5: In the deep suspension, irq_pending has no effect: with ext_irq = 0 all three enables stay 0.
- R6: In the deep suspension, ext_irq = 1 drives periph_clk_en and main_clk_en to 1 in the same cycle, and cpu_run_en is 1 after the next edge.
- R7: A write with bit 0 = 1 and bit 1 = 1 enters the deep suspension only, with the same enables as R4.
- R8: Writes made while a suspension is active are ignored. After the wake, the core runs with all enables at 1.
- R9: Bits 7 to 2 of the written byte are ignored. A write with bits 1 and 0 both clear leaves the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the power control register |
| wr_data | input | REG_W | Written byte: bit 0 requests the light suspension, bit 1 the deep suspension |
| irq_pending | input | 1 | Resolved summary of pending interrupts |
| ext_irq | input | 1 | Raw external interrupt request |
| cpu_run_en | output | 1 | Core may fetch and execute |
| periph_clk_en | output | 1 | Enable for the timer and peripheral clock |
| main_clk_en | output | 1 | Enable for the main clock |

## Verification
The assertions assume that the two mode bits are never set together. They also assume that a wake input seen at an edge is acted on at that edge, so each check names the mode the block is in before the edge. They assume nothing about how long irq_pending or ext_irq stay high. The stimulus drives random writes, including writes of both bits and of upper bits, and random pulses on both interrupt inputs, all at the falling edge. Writes keep arriving during suspensions to exercise the ignore rule. Directed sequences add the deep-suspension case in which only irq_pending is high, and the cycle in which ext_irq restarts the clocks.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int REG_W    = 8,
  parameter int HALT_BIT = 0,
  parameter int HOLD_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_pending,
  input  logic             ext_irq,
  output logic             cpu_run_en,
  output logic             periph_clk_en,
  output logic             main_clk_en
);

  logic halt_q, hold_q;
  logic running, wake_light, wake_deep;

  assign running    = !halt_q && !hold_q;
  assign wake_light = halt_q && (irq_pending || ext_irq);
  assign wake_deep  = hold_q && ext_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (running) begin
      if (wr_en) begin
        hold_q <= wr_data[HOLD_BIT];
        halt_q <= wr_data[HALT_BIT] && !wr_data[HOLD_BIT];
      end
    end else begin
      if (wake_light) halt_q <= 1'b0;
      if (wake_deep)  hold_q <= 1'b0;
    end
  end

  assign cpu_run_en    = running;
  assign periph_clk_en = !hold_q || ext_irq;
  assign main_clk_en   = !hold_q || ext_irq;

  // R2
  light_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_en && wr_data[HALT_BIT] && !wr_data[HOLD_BIT]
      |=> !cpu_run_en && periph_clk_en && main_clk_en);

  // R3
  light_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && (irq_pending || ext_irq) |=> cpu_run_en);

  // R4
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_en && wr_data[HOLD_BIT] |=> !cpu_run_en);

  // R5
  deep_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && !ext_irq |=> !cpu_run_en);

  // R6
  deep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && ext_irq |=> cpu_run_en && main_clk_en);

  // R8
  light_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !irq_pending && !ext_irq |=> !cpu_run_en && periph_clk_en);

  // R7
  always_comb begin
    one_mode_chk: assert (!(halt_q && hold_q));
  end

endmodule

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_pending = 1'b0;
  logic ext_irq = 1'b0;
  logic cpu_run_en, periph_clk_en, main_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] st = 2'b00; // {deep, light}

  always #4 clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pending(irq_pending), .ext_irq(ext_irq),
    .cpu_run_en(cpu_run_en), .periph_clk_en(periph_clk_en), .main_clk_en(main_clk_en));

  function automatic logic [1:0] nxt(input logic [1:0] s, input logic we,
                                     input logic [7:0] d, input logic irq, input logic ext);
    if (s == 2'b00) return we ? {d[1], d[0] & ~d[1]} : s;
    if (s[1]) return ext ? 2'b00 : s;
    return (irq || ext) ? 2'b00 : s;
  endfunction

  function automatic logic [2:0] expect_out(input logic [1:0] s, input logic ext);
    return {s == 2'b00, !s[1] || ext, !s[1] || ext};
  endfunction

  task automatic check(input string req);
    logic [2:0] exp, act;
    exp = expect_out(st, ext_irq);
    act = {cpu_run_en, periph_clk_en, main_clk_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: run/periph/main = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [7:0] d, input logic irq,
                       input logic ext, input string req);
    @(negedge clk);
    wr_en = we; wr_data = d; irq_pending = irq; ext_irq = ext;
    #1 check(req);
    @(posedge clk);
    st = nxt(st, we, d, irq, ext);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset state");
    cycle(0, 8'h00, 0, 0, "R1 idle");
    cycle(1, 8'h01, 0, 0, "R1 before light write");
    cycle(0, 8'h00, 0, 0, "R2 light entered");
    cycle(1, 8'h02, 0, 0, "R8 write during light");
    cycle(0, 8'h00, 0, 0, "R8 still light");
    cycle(0, 8'h00, 1, 0, "R3 irq_pending wake");
    cycle(0, 8'h00, 0, 0, "R3 running after irq wake");
    cycle(1, 8'h01, 0, 0, "R2 second entry");
    cycle(0, 8'h00, 0, 1, "R3 ext_irq wakes light");
    cycle(0, 8'h00, 0, 0, "R3 running after ext wake");
    cycle(1, 8'h02, 0, 0, "R4 deep write");
    cycle(0, 8'h00, 0, 0, "R4 deep entered");
    cycle(0, 8'h00, 1, 0, "R5 irq_pending ignored in deep");
    cycle(1, 8'h00, 1, 0, "R8 write during deep");
    cycle(0, 8'h00, 0, 0, "R5 still deep");
    cycle(0, 8'h00, 0, 1, "R6 ext_irq restarts clocks");
    cycle(0, 8'h00, 0, 0, "R6 running after deep wake");
    cycle(1, 8'h03, 0, 0, "R7 both bits written");
    cycle(0, 8'h00, 1, 0, "R7 deep wins over light");
    cycle(0, 8'h00, 0, 1, "R7 ext wake");
    cycle(1, 8'hFC, 0, 0, "R9 upper bits write");
    cycle(0, 8'h00, 0, 0, "R9 still running");
    cycle(1, 8'h00, 0, 0, "R9 zero write");
    cycle(0, 8'h00, 0, 0, "R9 running after zero write");
    for (int i = 0; i < 3000; i++) begin
      logic we, irq, ext;
      logic [7:0] d;
      we  = ($urandom % 4) == 0;
      d   = 8'($urandom);
      irq = ($urandom % 8) == 0;
      ext = ($urandom % 16) == 0;
      if (st[1])      cycle(we, d, irq, ext, "R5/R6 random deep");
      else if (st[0]) cycle(we, d, irq, ext, "R3/R8 random light");
      else            cycle(we, d, irq, ext, "R2/R4/R7/R9 random running");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule